// File: doc/BRIEF.md
# Dual-Clock Sample Snapshot Buffer

This block keeps a snapshot of converter data so a host can read it back later. On every rising edge of the capture clock where the write strobe is high, it stores one wide word at the given row. The wide word packs four channel samples. The store has no back-pressure: there is no ready signal on the capture side, so the producer never stalls, and a write that is presented is always taken. The host reads through a 32-bit Wishbone classic slave port that runs on its own clock, unrelated to the capture clock.

Before a word is stored, its four channel lanes are rearranged. Channels are grouped into sets that fill one 32-bit bus word. The order of the groups is reversed, and the order inside each group is kept. Rows are then cut into 32-bit slices, with slice 0 taken from the least significant end. As a result, bus words come back in channel order for 8-, 16- and 32-bit channels. The channel width is set by `LOG_WORD_W` (5, 6 or 7, giving wide words of 32, 64 or 128 bits). The depth is 2^`ADDR_W` rows. Bus address bits [1:0] are not part of the port. The word address is the row number followed by the slice number.

Top module: `snap_capture_buf`

## Requirements
- R1: While `wb_rst_i` is high, and in the first bus cycle after it falls, `wb_ack_o` is low.
- R2: When `wb_cyc_i` and `wb_stb_i` are both high at a bus clock edge where `wb_ack_o` is low, `wb_ack_o` is high for exactly the following cycle. If the request is held, acknowledges alternate high and low. No request means no acknowledge in the next cycle.
- R3: `wb_err_o` is never high.
- R4: A capture clock edge with `usr_we` high stores `usr_data` at row `usr_addr`. With `usr_we` low, the stored rows do not change.
- R5: With `LOG_WORD_W`=5 (channel 1 in `usr_data[31:24]` down to channel 4 in `[7:0]`), the bus word at byte address 4·row returns the row exactly as written: {ch1,ch2,ch3,ch4}.
- R6: With `LOG_WORD_W`=6 (channel 1 in `usr_data[63:48]`), the row is stored as {ch3,ch4,ch1,ch2}. Byte address 8·row returns {ch1,ch2}, and 8·row+4 returns {ch3,ch4}.
- R7: With `LOG_WORD_W`=7 (channel 1 in `usr_data[127:96]`), the row is stored as {ch4,ch3,ch2,ch1}. Byte address 16·row+4·s returns channel s+1.
- R8: A bus cycle with `wb_we_i` high is acknowledged like a read. It leaves the stored rows and `wb_dat_o` unchanged.
- R9: Asserting `wb_rst_i` does not clear the stored rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| usr_clk | input | 1 | Capture clock |
| usr_we | input | 1 | Store strobe for the current capture cycle |
| usr_addr | input | ADDR_W | Row written |
| usr_data | input | 2^LOG_WORD_W | Four packed channel samples, channel 1 in the top lane |
| wb_clk_i | input | 1 | Bus clock |
| wb_rst_i | input | 1 | Synchronous reset of the bus handshake |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write flag (writes are ignored) |
| wb_adr_i | input | ADDR_W+LOG_WORD_W-5 | Byte address bits from 2 upward: slice number, then row |
| wb_ack_o | output | 1 | Cycle acknowledge, valid with data |
| wb_err_o | output | 1 | Error flag, always low |
| wb_dat_o | output | 32 | Read data |

## Verification
The bench builds three copies of the block at the default depth of 1024 rows, with `LOG_WORD_W` set to 5, 6 and 7. All three receive the same capture and bus stimulus. This covers every lane permutation, and every slice count from one to four. The default depth also brings the first and last rows, with the widest row address, into the directed cases.

// File: rtl/snap_cap_pkg.sv
package snap_cap_pkg;
  localparam int LANES = 4;
  localparam int BUS_W = 32;

  // For an output lane position (0 = most significant), this returns the input
  // channel index (0 = most significant) that feeds it. Groups that fill one
  // bus word are listed in reverse order, and lanes inside a group keep their order.
  function automatic int lane_src(input int pos, input int cw);
    int grp;
    int ngrp;
    grp  = (cw >= BUS_W) ? 1 : BUS_W / cw;
    ngrp = LANES / grp;
    return (ngrp - 1 - pos / grp) * grp + (pos % grp);
  endfunction
endpackage

// File: rtl/snap_lane_order.sv
module snap_lane_order #(
  parameter int LOG_WORD_W = 5,
  parameter int WORD_W     = 1 << LOG_WORD_W
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  import snap_cap_pkg::*;
  localparam int CW = WORD_W / LANES;

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    localparam int SRC = lane_src(p, CW);
    assign dout[(LANES-1-p)*CW +: CW] = din[(LANES-1-SRC)*CW +: CW];
  end
endmodule

// File: rtl/snap_dp_store.sv
module snap_dp_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/snap_bus_read.sv
module snap_bus_read #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int SLICE_W = $clog2(DATA_W / 32),
  parameter int WADR_W  = ADDR_W + SLICE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc,
  input  logic              stb,
  input  logic              we,
  input  logic [WADR_W-1:0] wadr,
  output logic              ack,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_row,
  input  logic [DATA_W-1:0] mem_row_data,
  output logic [31:0]       dat
);
  import snap_cap_pkg::*;
  logic take;

  assign take    = cyc & stb & ~ack;
  assign mem_re  = take & ~we;
  assign mem_row = wadr[WADR_W-1 -: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= take;
  end

  if (SLICE_W == 0) begin : g_single
    assign dat = mem_row_data[BUS_W-1:0];
  end else begin : g_slices
    logic [SLICE_W-1:0] slice_q;
    always_ff @(posedge clk) begin
      if (mem_re) slice_q <= wadr[SLICE_W-1:0];
    end
    assign dat = mem_row_data[slice_q*BUS_W +: BUS_W];
  end
endmodule

// File: rtl/snap_capture_buf.sv
module snap_capture_buf #(
  parameter int LOG_WORD_W = 5,
  parameter int ADDR_W     = 10
) (
  input  logic                           usr_clk,
  input  logic                           usr_we,
  input  logic [ADDR_W-1:0]              usr_addr,
  input  logic [(1<<LOG_WORD_W)-1:0]     usr_data,
  input  logic                           wb_clk_i,
  input  logic                           wb_rst_i,
  input  logic                           wb_cyc_i,
  input  logic                           wb_stb_i,
  input  logic                           wb_we_i,
  input  logic [ADDR_W+LOG_WORD_W-4:2]   wb_adr_i,
  output logic                           wb_ack_o,
  output logic                           wb_err_o,
  output logic [31:0]                    wb_dat_o
);
  localparam int WORD_W  = 1 << LOG_WORD_W;
  localparam int SLICE_W = LOG_WORD_W - 5;
  localparam int WADR_W  = ADDR_W + SLICE_W;

  logic [WORD_W-1:0] ordered;
  logic [WORD_W-1:0] row_data;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_row;

  snap_lane_order #(.LOG_WORD_W(LOG_WORD_W), .WORD_W(WORD_W)) u_order (
    .din  (usr_data),
    .dout (ordered)
  );

  snap_dp_store #(.DATA_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .wr_clk  (usr_clk),
    .wr_en   (usr_we),
    .wr_addr (usr_addr),
    .wr_data (ordered),
    .rd_clk  (wb_clk_i),
    .rd_en   (rd_en),
    .rd_addr (rd_row),
    .rd_data (row_data)
  );

  snap_bus_read #(
    .DATA_W(WORD_W), .ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .WADR_W(WADR_W)
  ) u_bus (
    .clk          (wb_clk_i),
    .rst          (wb_rst_i),
    .cyc          (wb_cyc_i),
    .stb          (wb_stb_i),
    .we           (wb_we_i),
    .wadr         (wb_adr_i),
    .ack          (wb_ack_o),
    .mem_re       (rd_en),
    .mem_row      (rd_row),
    .mem_row_data (row_data),
    .dat          (wb_dat_o)
  );

  assign wb_err_o = 1'b0;
endmodule

// File: rtl/snap_capture_chk.sv
module snap_capture_chk (
  input logic        clk,
  input logic        rst,
  input logic        cyc,
  input logic        stb,
  input logic        we,
  input logic        ack,
  input logic [31:0] dat
);
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !ack);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r2_answers_request: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ack) |=> ack);

  a_r2_no_unasked_ack: assert property (@(posedge clk) disable iff (rst)
    !(cyc && stb) |=> !ack);

  a_r8_write_keeps_data: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && we && !ack) |=> $stable(dat));
endmodule

bind snap_capture_buf snap_capture_chk u_chk (
  .clk (wb_clk_i),
  .rst (wb_rst_i),
  .cyc (wb_cyc_i),
  .stb (wb_stb_i),
  .we  (wb_we_i),
  .ack (wb_ack_o),
  .dat (wb_dat_o)
);

// File: tb/sim_snap_capture_buf.sv
module sim_snap_capture_buf;
  logic wclk = 1'b0;
  logic uclk = 1'b0;
  always #4 wclk = ~wclk;
  always #5 uclk = ~uclk;

  logic        rst, cyc, stb, we, uwe;
  logic [31:0] ba0, ba1, ba2;
  logic [9:0]  uaddr;
  logic [127:0] udata;
  logic        ack0, ack1, ack2, err0, err1, err2;
  logic [31:0] dat0, dat1, dat2;

  logic [127:0] shadow [1024];
  bit           known  [1024];
  int n_cmp = 0;
  int n_bad = 0;

  snap_capture_buf #(.LOG_WORD_W(5), .ADDR_W(10)) u0 (
    .usr_clk(uclk), .usr_we(uwe), .usr_addr(uaddr), .usr_data(udata[31:0]),
    .wb_clk_i(wclk), .wb_rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(ba0[11:2]), .wb_ack_o(ack0), .wb_err_o(err0), .wb_dat_o(dat0));
  snap_capture_buf #(.LOG_WORD_W(6), .ADDR_W(10)) u1 (
    .usr_clk(uclk), .usr_we(uwe), .usr_addr(uaddr), .usr_data(udata[63:0]),
    .wb_clk_i(wclk), .wb_rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(ba1[12:2]), .wb_ack_o(ack1), .wb_err_o(err1), .wb_dat_o(dat1));
  snap_capture_buf #(.LOG_WORD_W(7), .ADDR_W(10)) u2 (
    .usr_clk(uclk), .usr_we(uwe), .usr_addr(uaddr), .usr_data(udata),
    .wb_clk_i(wclk), .wb_rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(ba2[13:2]), .wb_ack_o(ack2), .wb_err_o(err2), .wb_dat_o(dat2));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bus word expected for slice s of a row holding raw packed data.
  function automatic logic [31:0] expw(input int lg, input logic [127:0] raw, input int s);
    int ns;
    ns = 1 << (lg - 5);
    return raw[(ns-1-s)*32 +: 32];
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic uwrite(input int row, input logic [127:0] d, input bit en);
    @(negedge uclk);
    uaddr = row[9:0]; udata = d; uwe = en;
    @(negedge uclk);
    uwe = 1'b0;
    if (en) begin shadow[row] = d; known[row] = 1'b1; end
  endtask

  task automatic bcycle(input int row, input int s, input bit wr,
                        output logic [31:0] d0, output logic [31:0] d1, output logic [31:0] d2);
    @(negedge wclk);
    ba0 = row * 4; ba1 = row * 8 + (s % 2) * 4; ba2 = row * 16 + (s % 4) * 4;
    cyc = 1'b1; stb = 1'b1; we = wr;
    @(negedge wclk);
    chk(ack0 && ack1 && ack2, "R2 ack after request", {29'd0, ack2, ack1, ack0}, 32'd7);
    d0 = dat0; d1 = dat1; d2 = dat2;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge wclk);
    chk(!ack0 && !ack1 && !ack2, "R2 ack single cycle", {29'd0, ack2, ack1, ack0}, 32'd0);
    chk(!err0 && !err1 && !err2, "R3 err low", {29'd0, err2, err1, err0}, 32'd0);
  endtask

  task automatic rcheck(input int row, input int s, input string tag);
    logic [31:0] d0, d1, d2;
    bcycle(row, s, 1'b0, d0, d1, d2);
    chk(d0 == expw(5, shadow[row], 0), {"R5 ", tag}, d0, expw(5, shadow[row], 0));
    chk(d1 == expw(6, shadow[row], s % 2), {"R6 ", tag}, d1, expw(6, shadow[row], s % 2));
    chk(d2 == expw(7, shadow[row], s % 4), {"R7 ", tag}, d2, expw(7, shadow[row], s % 4));
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog: actual %0d cycles expected completion", 150000);
    summary();
  end

  initial begin
    logic [31:0] d0, d1, d2, h0, h1, h2;
    logic [3:0] pat;
    int row;
    void'($urandom(32'd20240611));
    rst = 1'b1; cyc = 1'b0; stb = 1'b0; we = 1'b0; uwe = 1'b0;
    ba0 = '0; ba1 = '0; ba2 = '0; uaddr = '0; udata = '0;
    repeat (3) @(negedge wclk);
    chk(!ack0 && !ack1 && !ack2, "R1 ack in reset", {29'd0, ack2, ack1, ack0}, 32'd0);
    chk(!err0 && !err1 && !err2, "R3 err in reset", {29'd0, err2, err1, err0}, 32'd0);
    rst = 1'b0;
    @(negedge wclk);
    chk(!ack0 && !ack1 && !ack2, "R1 ack after reset", {29'd0, ack2, ack1, ack0}, 32'd0);

    // Directed: distinct channel values at the first and last rows.
    uwrite(0, 128'h11111111_22222222_33333333_44444444, 1'b1);
    uwrite(1023, 128'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D4, 1'b1);
    for (int s = 0; s < 4; s++) rcheck(0, s, "row 0");
    for (int s = 0; s < 4; s++) rcheck(1023, s, "last row");

    // R4: a strobe-low cycle leaves the row alone.
    uwrite(5, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1);
    uwrite(5, 128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF, 1'b0);
    for (int s = 0; s < 4; s++) rcheck(5, s, "R4 no store when strobe low");

    // R2: held request gives alternating acknowledges.
    @(negedge wclk);
    ba0 = 0; ba1 = 0; ba2 = 0; cyc = 1'b1; stb = 1'b1; we = 1'b0;
    pat = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge wclk);
      pat[3-k] = ack0 & ack1 & ack2;
    end
    cyc = 1'b0; stb = 1'b0;
    chk(pat == 4'b1010, "R2 held request pattern", {28'd0, pat}, 32'hA);
    @(negedge wclk);

    // R8: bus write is acknowledged and changes nothing.
    bcycle(1023, 1, 1'b0, h0, h1, h2);
    bcycle(0, 2, 1'b1, d0, d1, d2);
    chk(d0 == h0 && d1 == h1 && d2 == h2, "R8 data held on write", d2, h2);
    for (int s = 0; s < 4; s++) rcheck(0, s, "R8 row unchanged");

    // R9: reset keeps the rows.
    @(negedge wclk); rst = 1'b1;
    repeat (3) @(negedge wclk);
    chk(!ack0 && !ack1 && !ack2, "R1 ack in second reset", {29'd0, ack2, ack1, ack0}, 32'd0);
    rst = 1'b0;
    for (int s = 0; s < 4; s++) rcheck(1023, s, "R9 kept over reset");

    // Random capture then random readback.
    for (int k = 0; k < 40; k++) begin
      row = $urandom_range(0, 1023);
      uwrite(row, {$urandom, $urandom, $urandom, $urandom}, 1'b1);
    end
    for (int k = 0; k < 80; k++) begin
      row = $urandom_range(0, 1023);
      if (known[row]) rcheck(row, $urandom_range(0, 3), "random");
    end
    summary();
  end
endmodule